// File: doc/BRIEF.md
# Dual-Rail Four-Phase Handshake Stage

This block wraps one stage of a dual-rail asynchronous pipeline. Each logical bit travels on a pair of rails, a "true" rail and a "false" rail. Code words alternate between valid data and a spacer. An input bank of two-input C-elements captures the upstream rails. Each element is gated by the stage's own acknowledge-in. The captured rails go through an enclosed function, which is either a straight pass-through or an external datapath attached through ports. They then reach an output bank of C-elements gated by the downstream stage's acknowledge. A completion detector watches the output bank and drives acknowledge-out, and acknowledge-in is its complement.

A single parameter selects the handshake polarity. With return-to-zero, the spacer is all rails low, data raises exactly one rail of each pair, and the detector ORs each pair. With return-to-one, the spacer is all rails high, data lowers exactly one rail of each pair, and the detector ANDs each pair. In both cases the per-pair results are merged by a binary tree of C-elements.

Every C-element is modelled in discrete time as a registered majority of its two inputs and its own output. A C-element therefore moves only when both inputs agree. Each rank of C-elements adds one clock of delay.

Top module: `dr_handshake_stage`

## Requirements
- R1: During reset, every rail of both banks holds the spacer value (all 0 for return-to-zero, all 1 for return-to-one), `ack_out` is 0 and `ack_in` is 1.
- R2: Encoding. For return-to-zero, a bit value of 1 is true=1/false=0, a bit value of 0 is true=0/false=1, and the spacer is 00. For return-to-one, a bit value of 1 is true=0/false=1, a bit value of 0 is true=1/false=0, and the spacer is 11. The output rails never carry the forbidden pair (11 for return-to-zero, 00 for return-to-one).
- R3: LVL = max(1, ceil(log2 WIDTH)). When a complete data word is presented and the downstream acknowledge lets it pass, `ack_out` changes on the (LVL+2)-th rising clock edge after the word is applied.
- R4: `ack_out` signals data completion (it rises for return-to-zero and falls for return-to-one) only when every output pair holds valid data. While any pair still shows the spacer, it does not change.
- R5: `ack_in` is always the complement of `ack_out`.
- R6: An input-bank rail takes the upstream rail value only when that value equals `ack_in`; otherwise it holds. Rails driven toward data while `ack_in` is in the wrong phase are ignored.
- R7: An output-bank rail takes its incoming value only when that value equals `dn_ack`. While the downstream stage holds `dn_ack` in the wrong phase, data waits in the input bank and `ack_out` does not change. Once `dn_ack` is released, `ack_out` changes LVL+1 edges later.
- R8: The spacer is handled symmetrically. For return-to-zero, a spacer applied after the acknowledge makes `ack_out` fall after LVL+2 edges with all output rails 0. For return-to-one, `ack_out` rises LVL edges after reset is released (spacer first), and again LVL+2 edges after each later spacer, with all output rails 1.
- R9: With `USE_EXT`=0, the output bank is fed from the input bank. With `USE_EXT`=1, it is fed from `fn_t`/`fn_f`, while `fwd_t`/`fwd_f` always show the input bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that steps the C-element model |
| rst_n | input | 1 | Asynchronous active-low reset to the spacer state |
| in_t | input | WIDTH | Upstream true rails |
| in_f | input | WIDTH | Upstream false rails |
| ack_out | output | 1 | Completion of the output bank |
| ack_in | output | 1 | Complement of ack_out; gates the input bank |
| fwd_t | output | WIDTH | Input-bank true rails, toward an external function |
| fwd_f | output | WIDTH | Input-bank false rails, toward an external function |
| fn_t | input | WIDTH | External function result, true rails |
| fn_f | input | WIDTH | External function result, false rails |
| dn_ack | input | 1 | Acknowledge-in of the downstream stage; gates the output bank |
| out_t | output | WIDTH | Output-bank true rails |
| out_f | output | WIDTH | Output-bank false rails |

## Verification
A C-element stuck in the wrong phase surfaces at the ports in one of two ways. Either `ack_out` fails to move within the fixed LVL+2 edge window, or it moves a different number of edges after the stimulus. So a latency count on every handshake catches both a hung stage and an extra or missing rank. A bank that wrongly accepts rails shows up within one or two edges as a forbidden or altered pair on `fwd_*` or `out_*`. The partial-word, back-pressure and out-of-phase rail cases hold the input steady for several cycles past the normal latency, so premature completion is visible before the word is finished.

// File: rtl/dr_handshake_stage.sv
module dr_handshake_stage #(
  parameter int WIDTH   = 8,
  parameter bit RTZ     = 1'b1,
  parameter bit USE_EXT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_t,
  input  logic [WIDTH-1:0] in_f,
  output logic             ack_out,
  output logic             ack_in,
  output logic [WIDTH-1:0] fwd_t,
  output logic [WIDTH-1:0] fwd_f,
  input  logic [WIDTH-1:0] fn_t,
  input  logic [WIDTH-1:0] fn_f,
  input  logic             dn_ack,
  output logic [WIDTH-1:0] out_t,
  output logic [WIDTH-1:0] out_f
);
  localparam int LVL = (WIDTH <= 2) ? 1 : $clog2(WIDTH);
  localparam int LEAVES = 1 << LVL;
  localparam logic [WIDTH-1:0] SPACER = RTZ ? '0 : '1;

  logic [WIDTH-1:0] bank_t, bank_f, mid_t, mid_f, done;
  logic [LEAVES-1:0] leaf;
  logic tree [1:LEAVES-1];

  // input bank: each rail meets ack_in at a C-element
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_t <= SPACER;
      bank_f <= SPACER;
    end else begin
      bank_t <= (in_t & {WIDTH{ack_in}}) | (in_t & bank_t) | ({WIDTH{ack_in}} & bank_t);
      bank_f <= (in_f & {WIDTH{ack_in}}) | (in_f & bank_f) | ({WIDTH{ack_in}} & bank_f);
    end
  end

  assign fwd_t = bank_t;
  assign fwd_f = bank_f;
  assign mid_t = USE_EXT ? fn_t : bank_t;
  assign mid_f = USE_EXT ? fn_f : bank_f;

  // output bank: each rail meets the downstream acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_t <= SPACER;
      out_f <= SPACER;
    end else begin
      out_t <= (mid_t & {WIDTH{dn_ack}}) | (mid_t & out_t) | ({WIDTH{dn_ack}} & out_t);
      out_f <= (mid_f & {WIDTH{dn_ack}}) | (mid_f & out_f) | ({WIDTH{dn_ack}} & out_f);
    end
  end

  assign done = RTZ ? (out_t | out_f) : (out_t & out_f);

  generate
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      localparam int SRC = (j < WIDTH) ? j : WIDTH - 1;
      assign leaf[j] = done[SRC];
    end
    for (genvar i = 1; i < LEAVES; i++) begin : g_node
      logic a, b;
      if (2 * i >= LEAVES) begin : g_from_leaf
        assign a = leaf[2*i-LEAVES];
        assign b = leaf[2*i+1-LEAVES];
      end else begin : g_from_node
        assign a = tree[2*i];
        assign b = tree[2*i+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tree[i] <= 1'b0;
        else        tree[i] <= (a & b) | (a & tree[i]) | (b & tree[i]);
      end
    end
  endgenerate

  assign ack_out = tree[1];
  assign ack_in  = ~ack_out;
endmodule

// File: rtl/dr_handshake_stage_chk.sv
module dr_handshake_stage_chk #(
  parameter int WIDTH = 8,
  parameter bit RTZ   = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_out,
  input logic             ack_in,
  input logic             dn_ack,
  input logic [WIDTH-1:0] fwd_t,
  input logic [WIDTH-1:0] fwd_f,
  input logic [WIDTH-1:0] out_t,
  input logic [WIDTH-1:0] out_f
);
  generate
    if (RTZ) begin : g_rtz
      assert_in_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        |({fwd_t, fwd_f} & ~$past({fwd_t, fwd_f})) |-> $past(ack_in));
      assert_out_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        |({out_t, out_f} & ~$past({out_t, out_f})) |-> $past(dn_ack));
      assert_ack_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> &(out_t ^ out_f));
      assert_ack_spacer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_out) |-> ({out_t, out_f} == '0));
      assert_legal_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(out_t & out_f)));
    end else begin : g_rto
      assert_in_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        |(~{fwd_t, fwd_f} & $past({fwd_t, fwd_f})) |-> !$past(ack_in));
      assert_out_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        |(~{out_t, out_f} & $past({out_t, out_f})) |-> !$past(dn_ack));
      assert_ack_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_out) |-> &(out_t ^ out_f));
      assert_ack_spacer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> ({out_t, out_f} == '1));
      assert_legal_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(~out_t & ~out_f)));
    end
  endgenerate
endmodule

bind dr_handshake_stage dr_handshake_stage_chk #(.WIDTH(WIDTH), .RTZ(RTZ)) u_chk (.*);

// File: tb/dr_handshake_stage_bench.sv
`timescale 1ns/1ps
module dr_handshake_stage_bench;
  localparam int W = 8;
  localparam int LVL = $clog2(W);
  localparam int LAT = LVL + 2;
  localparam int NV = 6;
  // {stimulus, expected through the inverting external function}
  localparam logic [15:0] VEC [NV] = '{16'h00FF, 16'hFF00, 16'hA55A, 16'h3CC3, 16'h01FE, 16'h807F};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a_in_t, a_in_f, a_fwd_t, a_fwd_f, a_out_t, a_out_f;
  logic a_ack, a_ackin, a_dn;
  logic [W-1:0] b_in_t, b_in_f, b_fwd_t, b_fwd_f, b_out_t, b_out_f;
  logic b_ack, b_ackin, b_dn;

  int n_chk = 0;
  int n_bad = 0;

  dr_handshake_stage #(.WIDTH(W), .RTZ(1'b1), .USE_EXT(1'b0)) u_dr_handshake_stage (
    .clk(clk), .rst_n(rst_n), .in_t(a_in_t), .in_f(a_in_f), .ack_out(a_ack), .ack_in(a_ackin),
    .fwd_t(a_fwd_t), .fwd_f(a_fwd_f), .fn_t('0), .fn_f('0), .dn_ack(a_dn),
    .out_t(a_out_t), .out_f(a_out_f));

  // return-to-one stage with a dual-rail inverter (rail swap) as external function
  dr_handshake_stage #(.WIDTH(W), .RTZ(1'b0), .USE_EXT(1'b1)) u_roh (
    .clk(clk), .rst_n(rst_n), .in_t(b_in_t), .in_f(b_in_f), .ack_out(b_ack), .ack_in(b_ackin),
    .fwd_t(b_fwd_t), .fwd_f(b_fwd_f), .fn_t(b_fwd_f), .fn_f(b_fwd_t), .dn_ack(b_dn),
    .out_t(b_out_t), .out_f(b_out_f));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ack(input bit roh, input logic target, output int n);
    n = 0;
    do begin
      @(posedge clk); n++; #1;
    end while (((roh ? b_ack : a_ack) !== target) && n < 40);
  endtask

  task automatic a_data(input logic [W-1:0] v);
    @(negedge clk); a_in_t = v; a_in_f = ~v;
  endtask
  task automatic a_space();
    @(negedge clk); a_in_t = '0; a_in_f = '0;
  endtask
  task automatic b_data(input logic [W-1:0] v);
    @(negedge clk); b_in_t = ~v; b_in_f = v;
  endtask
  task automatic b_space();
    @(negedge clk); b_in_t = '1; b_in_f = '1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] v;
    a_in_t = '0; a_in_f = '0; a_dn = 1'b1;
    b_in_t = '1; b_in_f = '1; b_dn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rtz out", {a_out_t, a_out_f}, '0);
    chk("R1 rtz fwd", {a_fwd_t, a_fwd_f}, '0);
    chk("R1 rtz acks", {a_ack, a_ackin}, 2'b01);
    chk("R1 rto out", {b_out_t, b_out_f}, {2*W{1'b1}});
    chk("R1 rto acks", {b_ack, b_ackin}, 2'b01);
    @(negedge clk); rst_n = 1'b1;

    // R8: return-to-one starts by acknowledging the spacer
    wait_ack(1'b1, 1'b1, n);
    chk("R8 rto spacer-first latency", n, LVL);
    @(negedge clk); b_dn = 1'b0;

    // vector walk: return-to-zero pass-through, then return-to-one inverted
    for (int k = 0; k < NV; k++) begin
      v = VEC[k][15:8];
      a_data(v);
      wait_ack(1'b0, 1'b1, n);
      chk("R3 rtz data latency", n, LAT);
      chk("R2 rtz out rails", {a_out_t, a_out_f}, {v, ~v});
      chk("R5 ack complement", {a_ack, a_ackin}, 2'b10);
      @(negedge clk); a_dn = 1'b0;
      a_space();
      wait_ack(1'b0, 1'b0, n);
      chk("R8 rtz spacer latency", n, LAT);
      chk("R8 rtz spacer out", {a_out_t, a_out_f}, '0);
      @(negedge clk); a_dn = 1'b1;
    end
    for (int k = 0; k < NV; k++) begin
      v = VEC[k][15:8];
      b_data(v);
      wait_ack(1'b1, 1'b0, n);
      chk("R3 rto data latency", n, LAT);
      chk("R9 rto inverted value", {b_out_t, b_out_f}, {v, VEC[k][7:0]});
      chk("R9 rto fwd shows bank", {b_fwd_t, b_fwd_f}, {~v, v});
      @(negedge clk); b_dn = 1'b1;
      b_space();
      wait_ack(1'b1, 1'b1, n);
      chk("R8 rto spacer latency", n, LAT);
      chk("R8 rto spacer out", {b_out_t, b_out_f}, {2*W{1'b1}});
      @(negedge clk); b_dn = 1'b0;
    end

    // R4: incomplete word must not complete (return-to-zero)
    v = 8'h96;
    @(negedge clk); a_in_t = {1'b0, v[W-2:0]}; a_in_f = {1'b0, ~v[W-2:0]};
    repeat (LAT + 3) @(posedge clk);
    #1 chk("R4 rtz partial holds ack", a_ack, 1'b0);
    @(negedge clk); a_in_t[W-1] = v[W-1]; a_in_f[W-1] = ~v[W-1];
    wait_ack(1'b0, 1'b1, n);
    chk("R4 rtz completes after last pair", n, LAT);

    // R6: rails pushed high while ack_in is low are ignored
    @(negedge clk); a_dn = 1'b0; a_in_t = '1; a_in_f = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 rtz bank holds", {a_fwd_t, a_fwd_f}, {v, ~v});
    chk("R6 rtz ack holds", a_ack, 1'b1);
    a_space();
    wait_ack(1'b0, 1'b0, n);
    chk("R6 rtz spacer after ignore", n, LAT);

    // R7: downstream back-pressure (a_dn still low)
    v = 8'h5C;
    a_data(v);
    repeat (LAT + 3) @(posedge clk);
    #1;
    chk("R7 ack held by downstream", a_ack, 1'b0);
    chk("R7 out stays spacer", {a_out_t, a_out_f}, '0);
    chk("R7 data waits in bank", {a_fwd_t, a_fwd_f}, {v, ~v});
    @(negedge clk); a_dn = 1'b1;
    wait_ack(1'b0, 1'b1, n);
    chk("R7 latency after release", n, LVL + 1);
    chk("R7 out after release", {a_out_t, a_out_f}, {v, ~v});
    @(negedge clk); a_dn = 1'b0;
    a_space();
    wait_ack(1'b0, 1'b0, n);
    @(negedge clk); a_dn = 1'b1;

    // R4: incomplete word in return-to-one
    v = 8'h3A;
    @(negedge clk); b_in_t = {1'b1, ~v[W-2:0]}; b_in_f = {1'b1, v[W-2:0]};
    repeat (LAT + 3) @(posedge clk);
    #1 chk("R4 rto partial holds ack", b_ack, 1'b1);
    @(negedge clk); b_in_t[W-1] = ~v[W-1]; b_in_f[W-1] = v[W-1];
    wait_ack(1'b1, 1'b0, n);
    chk("R4 rto completes after last pair", n, LAT);
    @(negedge clk); b_dn = 1'b1;
    b_space();
    wait_ack(1'b1, 1'b1, n);
    chk("R8 rto final spacer", n, LAT);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule